// File: doc/BRIEF.md
# DDR Interleaved I/Q Input Demultiplexer

This block sits between a parallel input bus and a dual-channel converter core. The bus carries I and Q samples one after the other at double data rate: one word is taken on each rising edge and one on each falling edge of the data clock. The block joins each two consecutive words into one I/Q pair. It hands that pair to the core as two parallel words, once per clock cycle, with a flag that marks the pair as valid.

Three control inputs set the mode. The order input decides whether the first word of a pair is I or Q. The edge input decides whether a pair opens on a rising edge and closes on the next falling edge, or opens on a falling edge and closes on the next rising edge. The format input tells the block whether input words are two's complement or unsigned offset binary. The outputs are always offset binary. The control inputs are taken only on an edge where the synchronous reset or the load strobe is high, so a mode change can never split a pair. After either event, both outputs rest at mid-scale until the first full pair has arrived.

Top module: `ddr_iq_demux`

## Requirements
- R1: On the first rising edge after one where `rst` is high, `out_vld` is 0 and both `i_out` and `q_out` equal the mid-scale code 2^(W-1).
- R2: Whenever `out_vld` is 0, `i_out` and `q_out` both equal the mid-scale code.
- R3: With the edge mode at 0, the word taken on a rising edge and the word taken on the falling edge that follows form one pair. That pair appears on the outputs after the next rising edge. The first valid pair appears after the second rising edge that follows reset or load.
- R4: With the edge mode at 1, the word taken on a falling edge and the word taken on the rising edge that follows form one pair. That pair appears on the outputs after that same rising edge. The first valid pair appears after the first rising edge that follows reset or load.
- R5: With the order mode at 0, the first word of a pair drives `i_out` and the second drives `q_out`. With the order mode at 1, the first word drives `q_out` and the second drives `i_out`.
- R6: With the format mode at 1, bit W-1 of each word is inverted on its way to the output. With the format mode at 0, words pass through unchanged.
- R7: Once `out_vld` is 1, it stays 1 on every cycle and a new pair appears each cycle, until the next reset or load.
- R8: `sel_q_lead`, `sel_fall_lead` and `sel_twos` have no effect except on a rising edge where `rst` or `ld_cfg` is high.
- R9: A rising edge with `ld_cfg` high takes the new mode. It also drives `out_vld` to 0 and the outputs to mid-scale on the next cycle, and pairing then restarts in the same way as after reset.
- R10: The word width W is a parameter intended for the values 8, 10, 12 and 14.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Data clock; words are taken on both of its edges |
| rst | input | 1 | Synchronous reset, active high; the mode inputs are taken while it is high |
| ld_cfg | input | 1 | Load strobe: takes the mode inputs and restarts pairing |
| sel_q_lead | input | 1 | Order mode: 1 makes the first word of a pair the Q word |
| sel_fall_lead | input | 1 | Edge mode: 1 makes a pair open on a falling edge |
| sel_twos | input | 1 | Format mode: 1 means input words are two's complement |
| din | input | W | Interleaved DDR data bus |
| i_out | output | W | I sample, offset binary |
| q_out | output | W | Q sample, offset binary |
| out_vld | output | 1 | High when `i_out` and `q_out` hold a complete pair |

## Verification
The assertions assume that `din` is stable around both clock edges. They also assume that `rst` is high at time zero, so that the mode copy in the checker starts out matching the design. The data check compares each output against the rising-edge word of the previous cycle. That check is made only in the falling-edge-first mode, where the second word of a pair is a rising-edge word. The stimulus meets these assumptions by changing `din` only 2 ns after each clock edge and by holding reset from the first instant. It also scrambles the mode inputs between loads to show that they are ignored there.

// File: rtl/ddr_iq_demux.sv
module ddr_iq_demux #(
  parameter int W = 14
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ld_cfg,
  input  logic         sel_q_lead,
  input  logic         sel_fall_lead,
  input  logic         sel_twos,
  input  logic [W-1:0] din,
  output logic [W-1:0] i_out,
  output logic [W-1:0] q_out,
  output logic         out_vld
);
  localparam logic [W-1:0] MID = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] fall_hold, rise_prev;
  logic         q_lead, fall_lead, twos, primed;
  logic [W-1:0] first_w, second_w, flip;

  always_ff @(negedge clk) fall_hold <= din;

  assign first_w  = fall_lead ? fall_hold : rise_prev;
  assign second_w = fall_lead ? din : fall_hold;
  assign flip     = twos ? MID : '0;

  always_ff @(posedge clk) begin
    rise_prev <= din;
    if (rst || ld_cfg) begin
      q_lead    <= sel_q_lead;
      fall_lead <= sel_fall_lead;
      twos      <= sel_twos;
      primed    <= 1'b0;
      out_vld   <= 1'b0;
      i_out     <= MID;
      q_out     <= MID;
    end else begin
      primed <= 1'b1;
      if (fall_lead || primed) begin
        out_vld <= 1'b1;
        i_out   <= (q_lead ? second_w : first_w) ^ flip;
        q_out   <= (q_lead ? first_w : second_w) ^ flip;
      end
    end
  end
endmodule

// File: rtl/ddr_iq_demux_chk.sv
module ddr_iq_demux_chk #(
  parameter int W = 14
) (
  input logic         clk,
  input logic         rst,
  input logic         ld_cfg,
  input logic         sel_q_lead,
  input logic         sel_fall_lead,
  input logic         sel_twos,
  input logic [W-1:0] din,
  input logic [W-1:0] i_out,
  input logic [W-1:0] q_out,
  input logic         out_vld
);
  localparam logic [W-1:0] MID = {1'b1, {(W-1){1'b0}}};

  logic ck_q, ck_fall, ck_twos;
  always_ff @(posedge clk)
    if (rst || ld_cfg) begin
      ck_q    <= sel_q_lead;
      ck_fall <= sel_fall_lead;
      ck_twos <= sel_twos;
    end

  // R1
  rst_mid_chk: assert property (@(posedge clk)
    rst |=> (!out_vld && i_out == MID && q_out == MID));

  // R9
  load_restart_chk: assert property (@(posedge clk) disable iff (rst)
    ld_cfg |=> (!out_vld && i_out == MID && q_out == MID));

  // R2
  idle_mid_chk: assert property (@(posedge clk) disable iff (rst)
    !out_vld |-> (i_out == MID && q_out == MID));

  // R7
  vld_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_vld && !ld_cfg) |=> out_vld);

  // R4 R5 R6
  fall_pair_chk: assert property (@(posedge clk) disable iff (rst)
    (out_vld && ck_fall) |->
      ((ck_q ? i_out : q_out) == ($past(din) ^ (ck_twos ? MID : '0))));
endmodule

bind ddr_iq_demux ddr_iq_demux_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .ld_cfg(ld_cfg), .sel_q_lead(sel_q_lead),
  .sel_fall_lead(sel_fall_lead), .sel_twos(sel_twos), .din(din),
  .i_out(i_out), .q_out(q_out), .out_vld(out_vld)
);

// File: tb/tb_ddr_iq_demux.sv
module tb_ddr_iq_demux;
  localparam int W = 14;
  localparam logic [W-1:0] MID = {1'b1, {(W-1){1'b0}}};

  logic clk = 1'b0;
  logic rst = 1'b1, ld_cfg = 1'b0;
  logic sel_q_lead = 1'b0, sel_fall_lead = 1'b0, sel_twos = 1'b0;
  logic [W-1:0] din = '0;
  logic [W-1:0] i_out, q_out;
  logic out_vld;

  always #5 clk = ~clk;

  ddr_iq_demux #(.W(W)) dut (
    .clk(clk), .rst(rst), .ld_cfg(ld_cfg), .sel_q_lead(sel_q_lead),
    .sel_fall_lead(sel_fall_lead), .sel_twos(sel_twos), .din(din),
    .i_out(i_out), .q_out(q_out), .out_vld(out_vld)
  );

  int checks = 0, fails = 0;
  logic mon_on = 1'b0;
  string tag = "R3";
  logic [2*W-1:0] sb[$];

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (mon_on) begin
      if (out_vld) begin
        if (sb.size() == 0) begin
          checks++; fails++;
          $display("FAIL %s: actual pair %h/%h expected none", tag, i_out, q_out);
        end else begin
          logic [2*W-1:0] e;
          e = sb.pop_front();
          chk({tag, " i"}, i_out, e[2*W-1:W]);
          chk({tag, " q"}, q_out, e[W-1:0]);
        end
      end else begin
        chk("R2 i", i_out, MID);
        chk("R2 q", q_out, MID);
      end
    end
  end

  task automatic start(input bit qf, input bit fs, input bit sg, input bit by_load);
    @(negedge clk);
    sel_q_lead = qf; sel_fall_lead = fs; sel_twos = sg;
    if (by_load) ld_cfg = 1'b1; else rst = 1'b1;
    @(posedge clk); #2;
    rst = 1'b0; ld_cfg = 1'b0;
    chk(by_load ? "R9 vld" : "R1 vld", {{(W-1){1'b0}}, out_vld}, '0);
    chk(by_load ? "R9 i" : "R1 i", i_out, MID);
    chk(by_load ? "R9 q" : "R1 q", q_out, MID);
  endtask

  task automatic run(input int n, input bit qf, input bit fs, input bit sg, input bit scramble);
    logic [W-1:0] fw, rw, prev_r, a, b, ei, eq, mask;
    mask = sg ? MID : '0;
    prev_r = '0;
    mon_on = 1'b1;
    for (int k = 0; k < n; k++) begin
      if (k == 1)
        chk(fs ? "R4 first vld" : "R3 first vld", {{(W-1){1'b0}}, out_vld}, {{(W-1){1'b0}}, fs});
      if (k >= 2)
        chk("R7 vld", {{(W-1){1'b0}}, out_vld}, {{(W-1){1'b0}}, 1'b1});
      fw = (k == 2) ? '1 : (k == 3) ? MID : W'($urandom);
      din = fw;
      if (scramble) begin
        sel_q_lead = 1'($urandom); sel_fall_lead = 1'($urandom); sel_twos = 1'($urandom);
      end
      @(negedge clk); #2;
      rw = (k == 2) ? '0 : (k == 3) ? (MID - 1'b1) : W'($urandom);
      din = rw;
      if (fs || k > 0) begin
        a = fs ? fw : prev_r;
        b = fs ? rw : fw;
        ei = (qf ? b : a) ^ mask;
        eq = (qf ? a : b) ^ mask;
        sb.push_back({ei, eq});
      end
      prev_r = rw;
      @(posedge clk); #2;
    end
    @(negedge clk); #1;
    mon_on = 1'b0;
    chk({tag, " drained"}, W'(sb.size()), '0);
    sb.delete();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    tag = "R3 R5 R10"; start(0, 0, 0, 0); run(40, 0, 0, 0, 0);
    tag = "R4 R5";     start(0, 1, 0, 0); run(40, 0, 1, 0, 0);
    tag = "R9 R3 R5 R6"; start(1, 0, 1, 1); run(40, 1, 0, 1, 0);
    tag = "R9 R4 R6";  start(1, 1, 1, 1); run(40, 1, 1, 1, 0);
    tag = "R8 R4 R6";  start(0, 1, 1, 1); run(60, 0, 1, 1, 1);
    tag = "R8 R3 R5";  start(1, 0, 0, 0); run(60, 1, 0, 0, 1);
    tag = "R1 R4";     start(1, 1, 0, 0); run(30, 1, 1, 0, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule